// File: doc/BRIEF.md
# AES3 Biphase-Mark Subframe Transmitter

This block turns one stereo sample pair per frame, together with each channel's validity, user and channel-status bits, into a single-ended biphase-mark line signal. Every frame carries two 32-slot subframes. Channel 1 carries left and channel 2 carries right. Each subframe opens with a four-slot sync preamble that deliberately breaks the biphase rule, so a receiver can find word, frame and block boundaries. The preamble type depends on the frame and subframe position. Its polarity follows the line level left by the previous subframe. An even-parity bit closes each subframe.

The block runs from a fast system clock and advances one line state for each pulse of a state-rate enable (128 times the sample rate, so two line states per slot). At the first line state of every frame it raises a one-cycle sample request. The surrounding logic presents the next frame's samples and flag bits during that cycle, and they are transmitted in the following frame. The block keeps a 192-frame block counter and drives a block-start flag. A timing reset parks the line high, and a mute parks it low. Both clear the position counters.

Top module: `aes3_bmc_tx`

## Requirements
- R1: During and after synchronous reset (`rst` high), `line_out` is 0, `blk_start` is 1 and `smp_req` is 0. All position counters and captured samples are cleared to zero.
- R2: The line advances exactly one state per `state_en` pulse while running, and holds its level on clocks without the enable. A frame is 128 states (64 per subframe, 2 per slot), and the frame index wraps from 191 back to 0.
- R3: Slots 0-3 of a subframe carry an 8-state preamble chosen by position. It is B = 11101000 for channel 1 of frame 0, M = 11100010 for channel 1 of any other frame and W = 11100100 for every channel 2 subframe, each sent first state first. If the line level just before the subframe is high, every state is inverted.
- R4: Slots 4-27 carry the 24-bit sample, with sample bit 0 in slot 4 and bit 23 in slot 27. Slot 28 carries validity, slot 29 the user bit and slot 30 the channel-status bit.
- R5: Slot 31 is chosen so that slots 4-31 hold an even number of ones.
- R6: Every data slot (4-31) starts by inverting the line level. A 1 inverts it again at the slot's second state, and a 0 keeps it.
- R7: `smp_req` goes high for exactly one clock, on the clock after the `state_en` that emits the first state of a frame. On the next clock edge the block captures all sample and flag inputs. The captured left set is sent in channel 1 and the right set in channel 2 of the following frame. Input values at all other clocks are ignored.
- R8: While running, `blk_start` is updated with each line state. It is 1 for line states whose position, counted as frame × 128 + state, is from 68 to 4163. That window starts two slots into channel 2 of frame 0 and spans 32 frames.
- R9: While `tmr_rst` is high, `line_out` becomes 1 and `blk_start` becomes 1 on the next clock, and `smp_req` is 0. After release, the next enabled state begins frame 0 with a B preamble.
- R10: While `mute` is high and `tmr_rst` is low, `line_out` becomes 0 and `blk_start` 1 on the next clock, and the position counters clear. When both are high, the timing-reset behaviour of R9 wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| state_en | input | 1 | One-clock pulse per line state (128 × fs) |
| tmr_rst | input | 1 | Timing reset: clears position, line parked high |
| mute | input | 1 | Mute: clears position, line parked low |
| left_smp | input | 24 | Channel 1 sample, two's complement |
| left_v | input | 1 | Channel 1 validity (1 = unreliable) |
| left_u | input | 1 | Channel 1 user bit |
| left_c | input | 1 | Channel 1 channel-status bit |
| right_smp | input | 24 | Channel 2 sample, two's complement |
| right_v | input | 1 | Channel 2 validity (1 = unreliable) |
| right_u | input | 1 | Channel 2 user bit |
| right_c | input | 1 | Channel 2 channel-status bit |
| line_out | output | 1 | Biphase-mark line level |
| blk_start | output | 1 | Block-start flag |
| smp_req | output | 1 | One-cycle request for the next frame's inputs |

## Verification
Two events can land on the same clock edge. One is the capture of fresh inputs while the sample request is high. The other is a line-state step, which happens when `state_en` pulses on consecutive clocks. The bench provokes this by running a stretch with the enable high on every clock and new input values on every clock. It then judges each emitted slot against a model that only accepts inputs present during its own predicted request cycle. The other collision, timing reset raised together with mute, is driven for several cycles and judged by the line parking high rather than low.

// File: rtl/aes3_tx_pkg.sv
package aes3_tx_pkg;

  localparam int SMP_W      = 24;
  localparam int SLOT_SMP0  = 4;
  localparam int SLOT_V     = 28;
  localparam int SLOT_U     = 29;
  localparam int SLOT_C     = 30;
  localparam int SLOT_PAR   = 31;
  localparam int ST_W       = 7;   // 128 states per frame

  typedef enum logic [1:0] {
    PRE_BLK  = 2'd0,
    PRE_CH1  = 2'd1,
    PRE_CH2  = 2'd2
  } pre_kind_e;

  typedef struct packed {
    logic [SMP_W-1:0] smp;
    logic             v;
    logic             u;
    logic             c;
  } chan_fields_t;

  // state sequence of each sync pattern for a low preceding level, first state in bit 7
  function automatic logic [7:0] pre_pattern(input pre_kind_e k);
    logic [7:0] p;
    case (k)
      PRE_BLK: p = 8'b1110_1000;
      PRE_CH1: p = 8'b1110_0010;
      default: p = 8'b1110_0100;
    endcase
    return p;
  endfunction

  // subframe payload word, slot index = bit index; slots 0..3 unused here
  function automatic logic [31:0] build_word(input chan_fields_t f);
    logic [31:0] w;
    w = '0;
    w[SLOT_SMP0 +: SMP_W] = f.smp;
    w[SLOT_V]             = f.v;
    w[SLOT_U]             = f.u;
    w[SLOT_C]             = f.c;
    w[SLOT_PAR]           = ^w[SLOT_C:SLOT_SMP0];
    return w;
  endfunction

endpackage

// File: rtl/aes3_tx_timebase.sv
module aes3_tx_timebase
  import aes3_tx_pkg::*;
#(
  parameter int BLOCK_FRAMES   = 192,
  parameter int BS_FRAMES      = 32,
  parameter int BS_DELAY_SLOTS = 2,
  localparam int FR_W          = $clog2(BLOCK_FRAMES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            state_en,
  output logic [FR_W-1:0] fr,
  output logic [ST_W-1:0] st,
  output logic            adv,
  output logic            smp_req,
  output logic            blk_start
);

  localparam logic [FR_W-1:0] LAST_FR = FR_W'(BLOCK_FRAMES - 1);
  localparam logic [FR_W-1:0] BS_FR   = FR_W'(BS_FRAMES);
  localparam logic [ST_W-1:0] BS_ST   = ST_W'(64 + 2 * BS_DELAY_SLOTS);
  localparam logic [ST_W-1:0] LAST_ST = '1;

  logic in_win;

  assign adv = state_en & run;

  always_comb begin
    if (fr == '0)
      in_win = (st >= BS_ST);
    else if (fr < BS_FR)
      in_win = 1'b1;
    else if (fr == BS_FR)
      in_win = (st < BS_ST);
    else
      in_win = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      fr        <= '0;
      st        <= '0;
      smp_req   <= 1'b0;
      blk_start <= 1'b1;
    end else begin
      smp_req <= 1'b0;
      if (state_en) begin
        st        <= st + 1'b1;
        blk_start <= in_win;
        if (st == '0)
          smp_req <= 1'b1;
        if (st == LAST_ST)
          fr <= (fr == LAST_FR) ? '0 : fr + 1'b1;
      end
    end
  end

  // R7
  smp_req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    smp_req |=> !smp_req);

  // R2
  fr_range_chk: assert property (@(posedge clk) disable iff (rst)
    fr <= LAST_FR);

  // R8
  blk_forced_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> blk_start);

  // R2
  hold_pos_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !state_en) |=> $stable(st));

endmodule

// File: rtl/aes3_tx_framer.sv
module aes3_tx_framer
  import aes3_tx_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            adv,
  input  logic [ST_W-1:0] st,
  input  logic            smp_req,
  input  chan_fields_t    in_l,
  input  chan_fields_t    in_r,
  output logic [31:0]     word
);

  localparam logic [ST_W-1:0] ST_CH1 = ST_W'(0);
  localparam logic [ST_W-1:0] ST_CH2 = ST_W'(64);

  chan_fields_t hold_l, hold_r, stage_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_l  <= '0;
      hold_r  <= '0;
      stage_r <= '0;
      word    <= '0;
    end else begin
      if (smp_req) begin
        hold_l <= in_l;
        hold_r <= in_r;
      end
      if (adv && st == ST_CH1) begin
        word    <= build_word(hold_l);
        stage_r <= hold_r;
      end else if (adv && st == ST_CH2) begin
        word <= build_word(stage_r);
      end
    end
  end

  // R5
  word_parity_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && (st == ST_CH1 || st == ST_CH2)) |=> (^word[31:4]) == 1'b0);

  // R7
  capture_chk: assert property (@(posedge clk) disable iff (rst)
    smp_req |=> (hold_l == $past(in_l)) && (hold_r == $past(in_r)));

endmodule

// File: rtl/aes3_bmc_coder.sv
module aes3_bmc_coder
  import aes3_tx_pkg::*;
#(
  parameter int FR_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tmr_rst,
  input  logic            mute,
  input  logic            adv,
  input  logic [FR_W-1:0] fr,
  input  logic [ST_W-1:0] st,
  input  logic [31:0]     word,
  output logic            line
);

  logic       ref_q, ref_now, pre_bit, nxt, sub_start, in_pre;
  logic [4:0] slot;
  logic [7:0] pat;
  pre_kind_e  kind;

  assign sub_start = (st[5:0] == 6'd0);
  assign in_pre    = (st[5:3] == 3'd0);
  assign slot      = st[5:1];

  always_comb begin
    if (st[6])
      kind = PRE_CH2;
    else if (fr == '0)
      kind = PRE_BLK;
    else
      kind = PRE_CH1;
  end

  assign pat     = pre_pattern(kind);
  assign ref_now = sub_start ? line : ref_q;
  assign pre_bit = pat[3'd7 - st[2:0]] ^ ref_now;

  always_comb begin
    if (in_pre)
      nxt = pre_bit;
    else if (!st[0])
      nxt = ~line;
    else
      nxt = word[slot] ? ~line : line;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line  <= 1'b0;
      ref_q <= 1'b0;
    end else if (tmr_rst) begin
      line <= 1'b1;
    end else if (mute) begin
      line <= 1'b0;
    end else if (adv) begin
      line <= nxt;
      if (sub_start)
        ref_q <= line;
    end
  end

  // R9
  line_hi_chk: assert property (@(posedge clk) disable iff (rst)
    tmr_rst |=> line);

  // R10
  line_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (mute && !tmr_rst) |=> !line);

  // R6
  slot_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !tmr_rst && !mute && !in_pre && !st[0]) |=> line != $past(line));

  // R3
  pre_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (adv && !tmr_rst && !mute && sub_start) |=> line != $past(line));

endmodule

// File: rtl/aes3_bmc_tx.sv
module aes3_bmc_tx
  import aes3_tx_pkg::*;
#(
  parameter int BLOCK_FRAMES   = 192,
  parameter int BS_FRAMES      = 32,
  parameter int BS_DELAY_SLOTS = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        state_en,
  input  logic        tmr_rst,
  input  logic        mute,
  input  logic [23:0] left_smp,
  input  logic        left_v,
  input  logic        left_u,
  input  logic        left_c,
  input  logic [23:0] right_smp,
  input  logic        right_v,
  input  logic        right_u,
  input  logic        right_c,
  output logic        line_out,
  output logic        blk_start,
  output logic        smp_req
);

  localparam int FR_W = $clog2(BLOCK_FRAMES);

  logic            run, adv;
  logic [FR_W-1:0] fr;
  logic [ST_W-1:0] st;
  logic [31:0]     word;
  chan_fields_t    in_l, in_r;

  assign run  = !tmr_rst && !mute;
  assign in_l = '{smp: left_smp,  v: left_v,  u: left_u,  c: left_c};
  assign in_r = '{smp: right_smp, v: right_v, u: right_u, c: right_c};

  aes3_tx_timebase #(
    .BLOCK_FRAMES  (BLOCK_FRAMES),
    .BS_FRAMES     (BS_FRAMES),
    .BS_DELAY_SLOTS(BS_DELAY_SLOTS)
  ) u_timebase (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .state_en (state_en),
    .fr       (fr),
    .st       (st),
    .adv      (adv),
    .smp_req  (smp_req),
    .blk_start(blk_start)
  );

  aes3_tx_framer u_framer (
    .clk    (clk),
    .rst    (rst),
    .adv    (adv),
    .st     (st),
    .smp_req(smp_req),
    .in_l   (in_l),
    .in_r   (in_r),
    .word   (word)
  );

  aes3_bmc_coder #(
    .FR_W(FR_W)
  ) u_coder (
    .clk    (clk),
    .rst    (rst),
    .tmr_rst(tmr_rst),
    .mute   (mute),
    .adv    (adv),
    .fr     (fr),
    .st     (st),
    .word   (word),
    .line   (line_out)
  );

  // R1
  rst_line_chk: assert property (@(posedge clk)
    rst |=> (!line_out && blk_start && !smp_req));

endmodule

// File: tb/aes3_bmc_tx_bench.sv
module aes3_bmc_tx_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        state_en = 1'b0, tmr_rst = 1'b0, mute = 1'b0;
  logic [23:0] left_smp = '0, right_smp = '0;
  logic        left_v = 0, left_u = 0, left_c = 0;
  logic        right_v = 0, right_u = 0, right_c = 0;
  logic        line_out, blk_start, smp_req;

  always #(CLK_PERIOD / 2) clk = ~clk;

  aes3_bmc_tx u_aes3_bmc_tx (
    .clk(clk), .rst(rst), .state_en(state_en), .tmr_rst(tmr_rst), .mute(mute),
    .left_smp(left_smp), .left_v(left_v), .left_u(left_u), .left_c(left_c),
    .right_smp(right_smp), .right_v(right_v), .right_u(right_u), .right_c(right_c),
    .line_out(line_out), .blk_start(blk_start), .smp_req(smp_req)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // reference model state
  int    m_fr = 0, m_st = 0;
  bit    m_line = 0, m_blk = 1, m_req = 0;
  bit    q[$];
  bit [26:0] hold_l = '0, hold_r = '0, stage_r = '0;   // {smp, v, u, c}
  string tag_line = "R1", tag_blk = "R1", tag_req = "R1";
  int    dmode = 0;

  task automatic push_subframe(input bit [26:0] f, input int kind, input bit pre_ref);
    bit [7:0] pat;
    bit lvl, b, par;
    pat = (kind == 0) ? 8'hE8 : (kind == 1) ? 8'hE2 : 8'hE4;
    for (int i = 7; i >= 0; i--) q.push_back(pat[i] ^ pre_ref);
    lvl = pat[0] ^ pre_ref;
    par = 0;
    for (int s = 4; s < 32; s++) begin
      if (s <= 27)      b = f[s - 1];
      else if (s == 28) b = f[2];
      else if (s == 29) b = f[1];
      else if (s == 30) b = f[0];
      else              b = par;
      par ^= b;
      lvl = ~lvl; q.push_back(lvl);
      if (b) lvl = ~lvl;
      q.push_back(lvl);
    end
  endtask

  function automatic bit in_window(input int fr, input int st);
    int idx = fr * 128 + st;
    return (idx >= 68) && (idx < 32 * 128 + 68);
  endfunction

  task automatic check_out();
    n_chk += 3;
    if (line_out !== m_line) begin
      n_bad++;
      $display("FAIL %s line_out got %b expected %b at %0t", tag_line, line_out, m_line, $time);
    end
    if (blk_start !== m_blk) begin
      n_bad++;
      $display("FAIL %s blk_start got %b expected %b at %0t", tag_blk, blk_start, m_blk, $time);
    end
    if (smp_req !== m_req) begin
      n_bad++;
      $display("FAIL %s smp_req got %b expected %b at %0t", tag_req, smp_req, m_req, $time);
    end
  endtask

  task automatic new_data();
    logic [31:0] r1, r2, r3;
    r1 = $urandom(); r2 = $urandom(); r3 = $urandom();
    case (dmode)
      1: begin left_smp = {r1[15:0], 8'h00}; right_smp = {r2[15:0], 8'h00}; end   // 16-bit style
      2: begin left_smp = r1[0] ? 24'hFFFFFF : 24'h800000;
               right_smp = r2[0] ? 24'h7FFFFF : 24'h000000; end
      default: begin left_smp = r1[23:0]; right_smp = r2[23:0]; end
    endcase
    {left_v, left_u, left_c, right_v, right_u, right_c} = r3[5:0];
  endtask

  task automatic model_step();
    bit nreq;
    int s;
    nreq = 0;
    if (rst) begin
      m_line = 0; m_blk = 1; m_fr = 0; m_st = 0; q.delete();
      hold_l = '0; hold_r = '0; stage_r = '0;
      tag_line = "R1"; tag_blk = "R1"; tag_req = "R1";
      m_req = 0;
      return;
    end
    tag_req = "R7";
    if (tmr_rst) begin
      m_line = 1; m_blk = 1; m_fr = 0; m_st = 0; q.delete();
      tag_line = "R9"; tag_blk = "R9";
    end else if (mute) begin
      m_line = 0; m_blk = 1; m_fr = 0; m_st = 0; q.delete();
      tag_line = "R10"; tag_blk = "R10";
    end else if (state_en) begin
      if (m_st == 0) begin
        q.delete();
        push_subframe(hold_l, (m_fr == 0) ? 0 : 1, m_line);
        stage_r = hold_r;
        nreq = 1;
      end else if (m_st == 64) begin
        q.delete();
        push_subframe(stage_r, 2, m_line);
      end
      s = m_st % 64;
      if (s < 8)                tag_line = "R3";
      else if (s % 2 == 0)      tag_line = "R6";
      else if (s / 2 == 31)     tag_line = "R5";
      else                      tag_line = "R4";
      tag_blk = "R8";
      m_line = q.pop_front();
      m_blk  = in_window(m_fr, m_st);
      m_st++;
      if (m_st == 128) begin
        m_st = 0;
        m_fr = (m_fr == 191) ? 0 : m_fr + 1;
      end
    end else begin
      tag_line = "R2"; tag_blk = "R2";
    end
    if (m_req) begin
      hold_l = {left_smp, left_v, left_u, left_c};
      hold_r = {right_smp, right_v, right_u, right_c};
    end
    m_req = nreq;
  endtask

  // one clock: check outputs, drive inputs, advance model to the next edge
  task automatic cyc(input bit en, input bit tr, input bit mu, input bit rs);
    @(negedge clk);
    check_out();
    rst = rs; state_en = en; tmr_rst = tr; mute = mu;
    new_data();
    model_step();
  endtask

  task automatic run_states(input int n, input int period);
    for (int i = 0; i < n; i++) begin
      cyc(1, 0, 0, 0);
      for (int k = 1; k < period; k++) cyc(0, 0, 0, 0);
    end
  endtask

  initial begin
    // R1: reset state
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1);
    // R2 R3 R4 R5 R6 R7 R8: full block plus wrap, enable every other clock
    run_states(195 * 128 + 37, 2);
    // R9: timing reset mid frame
    for (int i = 0; i < 5; i++) cyc(0, 1, 0, 0);
    // R7: enable on every clock, capture edge coincides with a state step
    dmode = 1;
    run_states(40 * 128 + 11, 1);
    // R10: mute
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0);
    dmode = 2;
    run_states(3 * 128 + 5, 3);
    // R10: timing reset and mute together, timing reset wins
    for (int i = 0; i < 3; i++) cyc(1, 1, 1, 0);
    dmode = 0;
    run_states(35 * 128, 3);
    // R1: reset in the middle of a run
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 1);
    run_states(2 * 128, 2);
    cyc(0, 0, 0, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R2 watchdog expired got running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule